// File: doc/BRIEF.md
# Toggle-Written Random Access Scan Grid

This block is a bank of state flip-flops that doubles as a random access test structure. The flops sit in a square grid. Each one is reached by a row line and a column line, and those lines come from two one-hot decoders fed by a binary address. During functional operation every flop loads its data input on each clock. In test mode only the flop picked by the address can change, and the only change it can make is to invert itself. Every other flop keeps its value.

Observation uses one shared bit, `scan_out`, which shows the addressed flop. Writing uses toggles, so no scan-in wire and no per-cell test-control wire reaches the grid. A tester loads a pattern in three steps. It reads each cell through `scan_out`, compares the value with its target, and issues one toggle for each mismatch. The cost of a load is therefore the Hamming distance between the current state and the target state.

The address is split into two fields. The upper `ROW_W` bits pick the row and the lower `COL_W` bits pick the column. The cell index is row*COLS+col, which equals the address when COLS is a power of two. The default grid is 4x4, which gives 16 cells and a 4-bit address.

Top module: `rast_grid`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, every bit of `q` is 0 after that edge. Reset takes priority over all other inputs.
- R2: When `test_mode` is 0 at a rising edge, `q` equals the `d` sampled at that edge.
- R3: When `test_mode` is 1 and `toggle_en` is 1 at a rising edge, bit `addr` of `q` inverts. Bit index `addr` means row `addr[3:2]` and column `addr[1:0]`, which is index row*4+col.
- R4: When `test_mode` is 1 and `toggle_en` is 0, `q` does not change, whatever the value of `d`.
- R5: When `test_mode` is 0, `toggle_en` has no effect: `q` still follows `d` exactly.
- R6: While `test_mode` is 1, `scan_out` equals bit `addr` of `q` in the same cycle. The output is combinational.
- R7: While `test_mode` is 0, `scan_out` is 0.
- R8: A toggle cycle changes exactly one bit of `q`. Internally, at most one cell is selected, and the row and column decoders are each one-hot in test mode and all-zero otherwise.
- R9: A tester can reach any target state through `scan_out` reads and toggles alone. The number of toggle cycles equals the count of bits that differ between the start state and the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low clear of all cells |
| test_mode | input | 1 | 1 enables the decoders and freezes functional capture |
| toggle_en | input | 1 | Test strobe: inverts the addressed cell |
| addr | input | 4 | Cell address, {row, column} |
| d | input | 16 | Functional data, one bit per cell |
| q | output | 16 | Stored cell values |
| scan_out | output | 1 | Value of the addressed cell in test mode, 0 otherwise |

## Verification
The properties assume that `test_mode`, `toggle_en` and `addr` are stable around each rising edge and hold a known value whenever reset is released. They also treat `toggle_en` during functional mode as legal but meaningless. The bench drives every input on the falling edge, so each change is settled half a period before the edge that uses it. It deliberately asserts `toggle_en` while `test_mode` is low, to exercise that case. Reads through `scan_out` are sampled before the inputs are changed again, so each observed value belongs to the address presented in that cycle.

// File: rtl/rast_pkg.sv
package rast_pkg;
  localparam int DEF_ROWS = 4;
  localparam int DEF_COLS = 4;

  // flat position of a cell from its row and column
  function automatic int cell_at(input int r, input int c, input int cols);
    return r * cols + c;
  endfunction

  // bits needed to number n items (at least one)
  function automatic int bits_for(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rast_onehot_dec.sv
module rast_onehot_dec #(
  parameter int W = 2,
  localparam int LINES = 1 << W
) (
  input  logic           en,
  input  logic [W-1:0]   sel,
  output logic [LINES-1:0] line
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign line[i] = en && (sel == W'(i));
  end
endmodule

// File: rtl/rast_cell.sv
module rast_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic flip,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       q <= 1'b0;
    else if (capture) q <= d;
    else if (flip)    q <= ~q;
  end
endmodule

// File: rtl/rast_readout.sv
module rast_readout #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int N = ROWS * COLS
) (
  input  logic [ROWS-1:0] row_line,
  input  logic [COLS-1:0] col_line,
  input  logic [N-1:0]    q,
  output logic            bit_out
);
  logic [N-1:0] term;
  for (genvar r = 0; r < ROWS; r++) begin : g_r
    for (genvar c = 0; c < COLS; c++) begin : g_c
      localparam int IDX = rast_pkg::cell_at(r, c, COLS);
      assign term[IDX] = row_line[r] & col_line[c] & q[IDX];
    end
  end
  assign bit_out = |term;
endmodule

// File: rtl/rast_grid.sv
module rast_grid #(
  parameter int ROWS = rast_pkg::DEF_ROWS,
  parameter int COLS = rast_pkg::DEF_COLS,
  localparam int ROW_W  = rast_pkg::bits_for(ROWS),
  localparam int COL_W  = rast_pkg::bits_for(COLS),
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int N      = ROWS * COLS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_mode,
  input  logic              toggle_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      d,
  output logic [N-1:0]      q,
  output logic              scan_out
);
  logic [(1<<ROW_W)-1:0] row_full;
  logic [(1<<COL_W)-1:0] col_full;
  logic [ROWS-1:0] row_line;
  logic [COLS-1:0] col_line;
  logic [N-1:0]    hit;
  logic            strobe;
  logic            func_en;

  assign func_en = ~test_mode;
  assign strobe  = test_mode & toggle_en;

  rast_onehot_dec #(.W(ROW_W)) u_row_dec (
    .en(test_mode), .sel(addr[ADDR_W-1:COL_W]), .line(row_full));
  rast_onehot_dec #(.W(COL_W)) u_col_dec (
    .en(test_mode), .sel(addr[COL_W-1:0]), .line(col_full));

  assign row_line = row_full[ROWS-1:0];
  assign col_line = col_full[COLS-1:0];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = rast_pkg::cell_at(r, c, COLS);
      assign hit[IDX] = row_line[r] & col_line[c];
      rast_cell u_cell (
        .clk(clk), .rst_n(rst_n), .capture(func_en),
        .flip(hit[IDX] & strobe), .d(d[IDX]), .q(q[IDX]));
    end
  end

  rast_readout #(.ROWS(ROWS), .COLS(COLS)) u_read (
    .row_line(row_line), .col_line(col_line), .q(q), .bit_out(scan_out));
endmodule

// File: rtl/rast_grid_chk.sv
module rast_grid_chk #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int ADDR_W = 4,
  localparam int N = ROWS * COLS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              test_mode,
  input logic              toggle_en,
  input logic [ADDR_W-1:0] addr,
  input logic [N-1:0]      d,
  input logic [N-1:0]      q,
  input logic              scan_out,
  input logic [ROWS-1:0]   row_line,
  input logic [COLS-1:0]   col_line,
  input logic [N-1:0]      hit
);
  localparam logic [N-1:0] ONE = N'(1);

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> q == '0);
  // R2
  func_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |=> q == $past(d));
  // R3
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && toggle_en) |=> q == ($past(q) ^ (ONE << $past(addr))));
  // R4
  test_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !toggle_en) |=> $stable(q));
  // R6
  read_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> scan_out == q[addr]);
  // R7
  read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> !scan_out);
  // R8
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
  // R8
  row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> $countones(row_line) == 1);
  // R8
  col_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> $countones(col_line) == 1);
  // R8
  lines_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> (row_line == '0 && col_line == '0));
endmodule

bind rast_grid rast_grid_chk #(.ROWS(ROWS), .COLS(COLS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .toggle_en(toggle_en),
  .addr(addr), .d(d), .q(q), .scan_out(scan_out),
  .row_line(row_line), .col_line(col_line), .hit(hit));

// File: tb/sim_rast_grid.sv
module sim_rast_grid;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 5000;
  localparam int NV = 9;
  // {test_mode, toggle_en, addr[3:0], d[15:0], exp_q[15:0], exp_scan}
  localparam logic [38:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd0,  16'hA5C3, 16'hA5C3, 1'b0},
    {1'b0, 1'b1, 4'd3,  16'h1234, 16'h1234, 1'b0},
    {1'b1, 1'b0, 4'd2,  16'hFFFF, 16'h1234, 1'b1},
    {1'b1, 1'b1, 4'd2,  16'h0000, 16'h1230, 1'b0},
    {1'b1, 1'b1, 4'd15, 16'h0000, 16'h9230, 1'b1},
    {1'b1, 1'b1, 4'd0,  16'hFFFF, 16'h9231, 1'b1},
    {1'b1, 1'b0, 4'd9,  16'h0000, 16'h9231, 1'b1},
    {1'b1, 1'b1, 4'd9,  16'hFFFF, 16'h9031, 1'b0},
    {1'b0, 1'b0, 4'd9,  16'h0F0F, 16'h0F0F, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n, test_mode, toggle_en, scan_out;
  logic [3:0]  addr;
  logic [15:0] d, q;
  int total = 0, bad = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rast_grid u0 (.clk(clk), .rst_n(rst_n), .test_mode(test_mode),
    .toggle_en(toggle_en), .addr(addr), .d(d), .q(q), .scan_out(scan_out));

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, return at next falling edge
  task automatic step(input logic tm, input logic te, input logic [3:0] a,
                      input logic [15:0] dv);
    test_mode = tm; toggle_en = te; addr = a; d = dv;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] prev, target, start;
    int flips;
    rst_n = 1'b0; test_mode = 1'b0; toggle_en = 1'b0; addr = '0; d = 16'hFFFF;
    @(negedge clk); @(negedge clk);
    // R1: reset wins over functional capture of d=FFFF
    chk(q == 16'h0, "R1 reset state", q, 16'h0);
    rst_n = 1'b1;

    // vector table: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      prev = q;
      step(VEC[i][38], VEC[i][37], VEC[i][36:33], VEC[i][32:17]);
      chk(q == VEC[i][16:1], $sformatf("R2/R3/R4/R5 vec%0d q", i), q, VEC[i][16:1]);
      chk(scan_out == VEC[i][0], $sformatf("R6/R7 vec%0d scan_out", i),
          16'(scan_out), 16'(VEC[i][0]));
      if (VEC[i][38] && VEC[i][37])
        chk($countones(q ^ prev) == 1, $sformatf("R8 vec%0d one bit", i),
            16'($countones(q ^ prev)), 16'd1);
    end

    // R6: read every address of a known pattern 0x0F0F without disturbing it
    for (int a = 0; a < 16; a++) begin
      step(1'b1, 1'b0, 4'(a), 16'hFFFF);
      chk(scan_out == start_bit(16'h0F0F, a), $sformatf("R6 read addr %0d", a),
          16'(scan_out), 16'(start_bit(16'h0F0F, a)));
    end
    chk(q == 16'h0F0F, "R4 hold across reads", q, 16'h0F0F);

    // R9: load 0x6A93 using only reads and toggles
    target = 16'h6A93; start = q; flips = 0;
    for (int a = 0; a < 16; a++) begin
      test_mode = 1'b1; toggle_en = 1'b0; addr = 4'(a); d = 16'h0;
      #1;
      if (scan_out != target[a]) begin
        step(1'b1, 1'b1, 4'(a), 16'h0);
        flips++;
      end
    end
    chk(q == target, "R9 target reached", q, target);
    chk(flips == $countones(start ^ target), "R9 toggle count",
        16'(flips), 16'($countones(start ^ target)));

    // R5: toggle_en high in functional mode, d=0000 must load as is
    step(1'b0, 1'b1, 4'd7, 16'h0000);
    chk(q == 16'h0000, "R5 toggle ignored", q, 16'h0000);
    chk(scan_out == 1'b0, "R7 idle read", 16'(scan_out), 16'h0);

    // R1: mid-run reset while toggling in test mode
    step(1'b0, 1'b0, 4'd0, 16'hBEEF);
    rst_n = 1'b0;
    step(1'b1, 1'b1, 4'd5, 16'hBEEF);
    chk(q == 16'h0000, "R1 mid-run reset", q, 16'h0000);
    rst_n = 1'b1;
    // R3: corner address 15 after reset
    step(1'b1, 1'b1, 4'd15, 16'h0);
    chk(q == 16'h8000, "R3 toggle top cell", q, 16'h8000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic start_bit(input logic [15:0] v, input int i);
    return v[i];
  endfunction
endmodule